// File: doc/BRIEF.md
# Acquisition and Sleep Sequencer

This block decides when a capacitive sensing burst runs, and it drives the ready line that a host reads before it talks to the sensor. It watches one active-low select line and the serial clock from the host. The select line has three jobs: it frames a transfer, it wakes the block from sleep, and it triggers a burst. When a transfer's clocking goes quiet, the block drops into sleep. A rising select then starts a settle interval, and a burst follows it. If select stays high, bursts repeat on their own. A short select pulse with no clocking asks for exactly one burst.

The block has two watchdogs. One watches for select held low too long. The other watches for clocking that runs too long. Either one sends the block through a one-cycle self-reset state into a fresh calibration. Calibration also runs after power-up, and the ready line stays low while it runs. Every duration is a parameter counted in system-clock ticks.

The select and serial clock inputs must already be synchronous to `clk`. The measuring side gets a one-cycle `burst_start` pulse and answers with `burst_done`.

Top module: `acq_sleep_seq`

## Requirements
- R1: After reset is released, `host_ready` stays low for exactly CAL_TICKS clock cycles of calibration and then goes high.
- R2: While idle-ready with `sel_n` high, `burst_start` pulses after FREE_PERIOD cycles spent in the ready state. Each burst ends in the cycle after `burst_done` is seen, and the free-running count then starts again.
- R3: During a transfer, the block enters sleep SLEEP_DLY cycles after the last detected rising edge of `ser_clk`, provided no further rising edge arrives. `host_ready` is low in sleep.
- R4: A rising edge of `sel_n` after a clocked transfer, whether in sleep or before sleep, drives `host_ready` low on the next cycle. `burst_start` follows SETTLE_DLY cycles after that edge is registered.
- R5: A low pulse on `sel_n` with no `ser_clk` rising edge forces one burst only when the number of ticks counted low lies within DUMMY_MIN to DUMMY_MAX inclusive. Shorter or longer pulses leave `host_ready` high and produce no `burst_start`.
- R6: A rising edge of `ser_clk` during sleep wakes the block: `host_ready` returns high and no burst starts until `sel_n` rises.
- R7: If `sel_n` stays low for SS_LOW_MAX ticks during a transfer or sleep, the block self-resets and recalibrates, with `host_ready` low for CAL_TICKS+1 cycles.
- R8: If clocking within one select frame spans CLK_MAX ticks, the block self-resets and recalibrates, with `host_ready` low.
- R9: `burst_start` is high for exactly one cycle per burst. `host_ready` stays low from that pulse until the cycle after `burst_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all delays count its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Host select, active low; frames transfers and triggers bursts |
| ser_clk | input | 1 | Host serial clock, synchronous to clk; only its activity is used |
| burst_done | input | 1 | Measuring side reports that the burst has finished |
| burst_start | output | 1 | One-cycle pulse that launches a sensing burst |
| host_ready | output | 1 | High when the host may clock a transfer; low in calibration, sleep, settle and burst |

## Verification
The bench builds the block with scaled delays: 40 ticks of calibration, 8 ticks of sleep, 12 ticks of settle, a 200-tick free-running period, a dummy window of 5 to 30 ticks, 150 ticks of clock span and 300 ticks of select-low. With these values, both watchdog trips and both self-reset recalibrations fit in a few hundred cycles. The dummy window can be probed from below and from above with short pulses. Because the free-running period is long, it does not disturb the vector walk, and it can still be timed to the exact cycle in a test of its own.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [2:0] {
    ST_CAL    = 3'd0,
    ST_READY  = 3'd1,
    ST_XFER   = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_BURST  = 3'd5,
    ST_SRST   = 3'd6
  } acq_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic in_window(input int unsigned v, input int unsigned lo,
                                     input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic ready_level(input acq_state_e s);
    return (s == ST_READY) || (s == ST_XFER);
  endfunction

  function automatic logic frame_state(input acq_state_e s);
    return (s == ST_XFER) || (s == ST_SLEEP);
  endfunction

endpackage

// File: rtl/acq_edge_bank.sv
module acq_edge_bank #(
  parameter int unsigned N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL[g];
      else        q <= din[g];
    end
    assign rise[g] = din[g] & ~q;
  end
endmodule

// File: rtl/acq_tick_counter.sv
module acq_tick_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (en && (cnt != '1))  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/acq_sleep_seq.sv
module acq_sleep_seq
  import acq_pkg::*;
#(
  parameter int unsigned CAL_TICKS   = 26250000,
  parameter int unsigned SLEEP_DLY   = 1750,
  parameter int unsigned SETTLE_DLY  = 50000,
  parameter int unsigned FREE_PERIOD = 2900000,
  parameter int unsigned DUMMY_MIN   = 500,
  parameter int unsigned DUMMY_MAX   = 500000,
  parameter int unsigned CLK_MAX     = 750000,
  parameter int unsigned SS_LOW_MAX  = 50000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic ser_clk,
  input  logic burst_done,
  output logic burst_start,
  output logic host_ready
);
  localparam int unsigned LIM_A = max_of(max_of(CAL_TICKS, SETTLE_DLY), FREE_PERIOD);
  localparam int unsigned LIM_B = max_of(max_of(SS_LOW_MAX, CLK_MAX), DUMMY_MAX);
  localparam int unsigned LIM_ALL = max_of(max_of(LIM_A, LIM_B), SLEEP_DLY);
  localparam int unsigned CW = $clog2(LIM_ALL + 1) + 1;

  localparam logic [CW-1:0] CAL_LAST    = CW'(CAL_TICKS - 1);
  localparam logic [CW-1:0] SLEEP_LAST  = CW'(SLEEP_DLY - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_DLY - 1);
  localparam logic [CW-1:0] FREE_LAST   = CW'(FREE_PERIOD - 1);
  localparam logic [CW-1:0] SPAN_LAST   = CW'(CLK_MAX - 1);
  localparam logic [CW-1:0] LOW_LAST    = CW'(SS_LOW_MAX - 1);

  acq_state_e state_q, state_n;

  // edge events, brought out for the checker
  logic [1:0] rise_vec;
  logic       ss_rise, sclk_rise;

  acq_edge_bank #(.N(2), .RST_VAL(2'b01)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_clk, sel_n}),
    .rise (rise_vec)
  );
  assign ss_rise   = rise_vec[0];
  assign sclk_rise = rise_vec[1];

  // clock activity seen in the current select frame
  logic seen_clk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen_clk <= 1'b0;
    else if (!frame_state(state_q)) seen_clk <= 1'b0;
    else if (sclk_rise)             seen_clk <= 1'b1;
  end

  // cycles spent in the current state
  logic [CW-1:0] dwell;
  acq_tick_counter #(.W(CW)) u_dwell (
    .clk(clk), .rst_n(rst_n), .clr(state_n != state_q), .en(1'b1), .cnt(dwell)
  );

  // ticks with select low inside a frame
  logic [CW-1:0] lowc;
  acq_tick_counter #(.W(CW)) u_low (
    .clk(clk), .rst_n(rst_n), .clr(sel_n || !frame_state(state_q)), .en(1'b1), .cnt(lowc)
  );

  // ticks since the last serial clock rising edge
  logic [CW-1:0] idlec;
  acq_tick_counter #(.W(CW)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(sclk_rise), .en(1'b1), .cnt(idlec)
  );

  // span of clocking in the current frame
  logic [CW-1:0] spanc;
  acq_tick_counter #(.W(CW)) u_span (
    .clk(clk), .rst_n(rst_n), .clr(sel_n || !seen_clk),
    .en(state_q == ST_XFER), .cnt(spanc)
  );

  // named events for the checker
  logic trip_low, trip_span, dummy_ok, quiet_done, xfer_valid;
  assign trip_low   = !sel_n && (lowc >= LOW_LAST);
  assign trip_span  = seen_clk && (spanc >= SPAN_LAST);
  assign dummy_ok   = !seen_clk && !sclk_rise &&
                      in_window(32'(lowc), DUMMY_MIN, DUMMY_MAX);
  assign xfer_valid = seen_clk || sclk_rise || dummy_ok;
  assign quiet_done = seen_clk && !sclk_rise && (idlec == SLEEP_LAST);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_CAL:    if (dwell == CAL_LAST) state_n = ST_READY;
      ST_READY: begin
        if (!sel_n)                  state_n = ST_XFER;
        else if (dwell == FREE_LAST) state_n = ST_BURST;
      end
      ST_XFER: begin
        if (trip_low || trip_span) state_n = ST_SRST;
        else if (ss_rise)          state_n = xfer_valid ? ST_SETTLE : ST_READY;
        else if (quiet_done)       state_n = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (trip_low)       state_n = ST_SRST;
        else if (ss_rise)   state_n = ST_SETTLE;
        else if (sclk_rise) state_n = ST_XFER;
      end
      ST_SETTLE: if (dwell == SETTLE_LAST) state_n = ST_BURST;
      ST_BURST:  if (burst_done) state_n = ST_READY;
      ST_SRST:   state_n = ST_CAL;
      default:   state_n = ST_CAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_CAL;
      burst_start <= 1'b0;
    end else begin
      state_q     <= state_n;
      burst_start <= (state_n == ST_BURST) && (state_q != ST_BURST);
    end
  end

  assign host_ready = ready_level(state_q);

endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk
  import acq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       burst_done,
  input logic       burst_start,
  input logic       host_ready,
  input acq_state_e st,
  input logic       ss_rise,
  input logic       sclk_rise,
  input logic       trip_low
);
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start);

  // R9
  start_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> !host_ready);

  // R4
  sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP && ss_rise) |=> (st == ST_SETTLE && !host_ready));

  // R6
  clk_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP && sclk_rise && !ss_rise && !trip_low) |=> (host_ready && !burst_start));

  // R2
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BURST && burst_done) |=> host_ready);

  // R7
  srst_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SRST) |=> (st == ST_CAL && !host_ready));

  // R7
  low_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_low && (st == ST_SLEEP || st == ST_XFER)) |=> (st == ST_SRST));

  // R3
  sleep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP) |-> !host_ready);
endmodule

bind acq_sleep_seq acq_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_n      (sel_n),
  .burst_done (burst_done),
  .burst_start(burst_start),
  .host_ready (host_ready),
  .st         (state_q),
  .ss_rise    (ss_rise),
  .sclk_rise  (sclk_rise),
  .trip_low   (trip_low)
);

// File: tb/sim_acq_sleep_seq.sv
module sim_acq_sleep_seq;
  localparam int CLK_P = 10;
  localparam int CAL = 40, SLP = 8, SET = 12, FREE = 200;
  localparam int DMIN = 5, DMAX = 30, CMAX = 150, LMAX = 300;
  localparam int NV = 32;

  // vector: {sel_n, ser_clk, done, cycles[7:0], exp_ready, exp_start}
  localparam logic [12:0] VEC [NV] = '{
    {3'b000, 8'd1,  2'b10}, {3'b010, 8'd1,  2'b10}, {3'b000, 8'd1, 2'b10},
    {3'b010, 8'd1,  2'b10}, {3'b000, 8'd1,  2'b10}, {3'b000, 8'd5, 2'b10},
    {3'b000, 8'd2,  2'b00},                                            // R3 sleep
    {3'b100, 8'd1,  2'b00}, {3'b100, 8'd11, 2'b00}, {3'b100, 8'd1, 2'b01}, // R4
    {3'b100, 8'd1,  2'b00}, {3'b101, 8'd1,  2'b10}, {3'b100, 8'd1, 2'b10},
    {3'b000, 8'd10, 2'b10}, {3'b100, 8'd1,  2'b00}, {3'b100, 8'd11, 2'b00}, // R5 dummy
    {3'b100, 8'd1,  2'b01}, {3'b101, 8'd1,  2'b10}, {3'b100, 8'd1, 2'b10},
    {3'b000, 8'd2,  2'b10}, {3'b100, 8'd1,  2'b10}, {3'b100, 8'd20, 2'b10}, // R5 short
    {3'b000, 8'd40, 2'b10}, {3'b100, 8'd1,  2'b10}, {3'b100, 8'd20, 2'b10}, // R5 long
    {3'b000, 8'd1,  2'b10}, {3'b010, 8'd1,  2'b10}, {3'b000, 8'd2, 2'b10},  // R4 early
    {3'b100, 8'd1,  2'b00}, {3'b100, 8'd11, 2'b00}, {3'b100, 8'd1, 2'b01},
    {3'b101, 8'd1,  2'b10}
  };
  localparam int VREQ [NV] = '{3,3,3,3,3,3,3, 4,4,9,9,9,9, 5,5,5,5,9,9,
                               5,5,5, 5,5,5, 4,4,4,4,4,9,9};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, ser_clk = 1'b0, burst_done = 1'b0;
  logic burst_start, host_ready;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  acq_sleep_seq #(
    .CAL_TICKS(CAL), .SLEEP_DLY(SLP), .SETTLE_DLY(SET), .FREE_PERIOD(FREE),
    .DUMMY_MIN(DMIN), .DUMMY_MAX(DMAX), .CLK_MAX(CMAX), .SS_LOW_MAX(LMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
    .burst_done(burst_done), .burst_start(burst_start), .host_ready(host_ready)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic outs(input string req, input logic rdy, input logic bs);
    chk(req, "host_ready", host_ready, rdy);
    chk(req, "burst_start", burst_start, bs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    outs("R1", 1'b0, 1'b0);                 // R1 reset state
    rst_n = 1'b1;
    step(CAL - 1);
    outs("R1", 1'b0, 1'b0);                 // R1 still calibrating
    step(1);
    outs("R1", 1'b1, 1'b0);                 // R1 ready

    for (int i = 0; i < NV; i++) begin
      sel_n      = VEC[i][12];
      ser_clk    = VEC[i][11];
      burst_done = VEC[i][10];
      step(int'(VEC[i][9:2]));
      outs($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][1], VEC[i][0]);
    end
    burst_done = 1'b0;

    // R2 free-running burst after FREE cycles in ready
    step(FREE - 1);
    outs("R2", 1'b1, 1'b0);
    step(1);
    outs("R2", 1'b0, 1'b1);
    step(1);
    outs("R9", 1'b0, 1'b0);
    burst_done = 1'b1; step(1);
    outs("R2", 1'b1, 1'b0);
    burst_done = 1'b0;

    // R6 clock wakes from sleep without a burst
    sel_n = 1'b0; step(1);
    ser_clk = 1'b1; step(1);
    ser_clk = 1'b0; step(SLP + 1);
    outs("R3", 1'b0, 1'b0);
    ser_clk = 1'b1; step(1);
    outs("R6", 1'b1, 1'b0);
    ser_clk = 1'b0; step(3);
    outs("R6", 1'b1, 1'b0);
    sel_n = 1'b1; step(1);
    outs("R4", 1'b0, 1'b0);
    step(SET);
    outs("R4", 1'b0, 1'b1);
    burst_done = 1'b1; step(1);
    outs("R9", 1'b1, 1'b0);
    burst_done = 1'b0;

    // R7 select held low past the limit
    sel_n = 1'b0; step(LMAX + 5);
    outs("R7", 1'b0, 1'b0);
    sel_n = 1'b1; step(CAL - 10);
    outs("R7", 1'b0, 1'b0);
    step(20);
    outs("R7", 1'b1, 1'b0);

    // R8 clocking span past the limit
    sel_n = 1'b0; step(1);
    for (int k = 0; k < 85; k++) begin
      ser_clk = 1'b1; step(1);
      ser_clk = 1'b0; step(1);
      if (k == 69) chk("R8", "host_ready mid-clocking", host_ready, 1'b1);
    end
    outs("R8", 1'b0, 1'b0);
    sel_n = 1'b1; step(CAL + 5);
    outs("R8", 1'b1, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule